// File: doc/BRIEF.md
# Software Interrupt Pending Register with Level Masking

This block keeps a 17-bit register of pending software interrupts and turns it into one request line per bit. Each bit position is an interrupt level. Bits 1 to 15 are ordinary software levels. Bit 0 is the tick-match level and bit 16 is the system-tick-match level. A 4-bit processor interrupt level (the current priority floor) decides which pending bits may raise a request. Software updates the pending register through one write port. A select code on that port picks one of three operations: replace the register, OR bits into it, or clear bits from it. A timer block can raise bit 16 directly with a one-cycle strobe.

All state sits in registers, and the request outputs are pure logic of those registers. Every write to the pending register or to the priority floor shows on the request lines one clock after the write. A request line falls as soon as its masking condition fails, and no acknowledge is needed. The port is a plain register port, so a write is taken in every cycle it is presented and there is no back-pressure. Turning the requests into a trap number, vectoring and acknowledging are left to a downstream block.

Top module: `soft_irq_ctrl`

## Requirements
- R1: After reset the pending register reads 0, the priority floor reads 15 and all 17 request lines are low.
- R2: A write with `wr_sel` = 2'b00 (replace) loads `wr_data` into the pending register. The result can be read on `pend_q` in the next cycle.
- R3: A write with `wr_sel` = 2'b01 (set alias) ORs `wr_data` into the pending register.
- R4: A write with `wr_sel` = 2'b10 (clear alias) ANDs the pending register with the inverse of `wr_data`.
- R5: A write with `wr_sel` = 2'b11, or a cycle with `wr_en` low and `tmr_set` low, leaves the pending register unchanged.
- R6: For bit index i from 1 to 15, `irq_req[i]` is high exactly when pending bit i is set and i is strictly greater than the priority floor.
- R7: `irq_req[0]` and `irq_req[16]` are high exactly when their pending bit is set and the priority floor is below 14. The floor's value within 14 to 15 plays no other part.
- R8: A floor write (`pil_we`) loads `pil_wdata`, which reads on `pil_q` in the next cycle. The request lines reflect the new floor in that same cycle, and the pending register does not change.
- R9: A `tmr_set` strobe sets pending bit 16 and leaves the other bits alone. When it comes in the same cycle as a register write, the write is applied first and bit 16 is set afterwards, so a clear of bit 16 in that cycle loses to the strobe.
- R10: A request line drops without any acknowledge once its masking condition stops holding, for example after the floor is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Pending-register write strobe |
| wr_sel | input | 2 | Write operation: 00 replace, 01 set, 10 clear, 11 none |
| wr_data | input | 17 | Write data / bit mask |
| pil_we | input | 1 | Priority floor write strobe |
| pil_wdata | input | 4 | New priority floor value |
| tmr_set | input | 1 | Timer strobe that sets pending bit 16 |
| pend_q | output | 17 | Current pending register |
| pil_q | output | 4 | Current priority floor |
| irq_req | output | 17 | Per-level interrupt request lines |

## Verification
The bench sets every bit and then moves the priority floor across the values 15, 14, 13 and 0. A compare that is off by one (`>=` instead of `>`) would leave bit 14 requesting at floor 14. A design that treated bits 0 and 16 like the others would drop them at floor 13 or raise them at floor 15. The bench also checks a timer strobe that comes in the same cycle as a clear of bit 16. If the design gave the alias priority, bit 16 would be lost. The unused select code and idle cycles are checked through `pend_q`, which catches a design that decodes code 11 as a replace or a clear. A floor write in the same cycle as a set write checks that the two paths update independently.

// File: rtl/soft_irq_pkg.sv
package soft_irq_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_SET   = 2'b01,
    OP_CLEAR = 2'b10,
    OP_NONE  = 2'b11
  } wr_op_e;

endpackage

// File: rtl/soft_irq_pend_reg.sv
module soft_irq_pend_reg
  import soft_irq_pkg::*;
#(
  parameter int PEND_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [PEND_W-1:0] wr_data,
  input  logic              tmr_set,
  output logic [PEND_W-1:0] pend_q
);

  localparam int TBIT = PEND_W - 1;

  logic [PEND_W-1:0] alias_res;
  logic [PEND_W-1:0] tmr_mask;
  logic [PEND_W-1:0] pend_d;

  // Apply the alias operation first, then the timer strobe.
  always_comb begin
    alias_res = pend_q;
    if (wr_en) begin
      unique case (wr_op_e'(wr_sel))
        OP_LOAD:  alias_res = wr_data;
        OP_SET:   alias_res = pend_q | wr_data;
        OP_CLEAR: alias_res = pend_q & ~wr_data;
        default:  alias_res = pend_q;
      endcase
    end
  end

  always_comb begin
    tmr_mask       = '0;
    tmr_mask[TBIT] = tmr_set;
    pend_d         = alias_res | tmr_mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

endmodule

// File: rtl/soft_irq_pil_reg.sv
module soft_irq_pil_reg #(
  parameter int PIL_W   = 4,
  parameter int PIL_RST = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pil_we,
  input  logic [PIL_W-1:0] pil_wdata,
  output logic [PIL_W-1:0] pil_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)      pil_q <= PIL_W'(PIL_RST);
    else if (pil_we) pil_q <= pil_wdata;
  end

endmodule

// File: rtl/soft_irq_mask.sv
module soft_irq_mask #(
  parameter int PIL_W      = 4,
  parameter int NLVL       = 16,
  parameter int TMR_THRESH = 14
) (
  input  logic [NLVL:0]    pend,
  input  logic [PIL_W-1:0] pil,
  output logic [NLVL:0]    req
);

  localparam int CW = PIL_W + 1;

  logic [CW-1:0] pil_x;
  logic          fixed_ok;

  assign pil_x    = {1'b0, pil};
  assign fixed_ok = pil_x < CW'(TMR_THRESH);

  // Timer levels at both ends use the fixed threshold.
  assign req[0]    = pend[0]    & fixed_ok;
  assign req[NLVL] = pend[NLVL] & fixed_ok;

  // Ordinary levels compare their own index against the floor.
  for (genvar i = 1; i < NLVL; i++) begin : g_lvl
    localparam logic [CW-1:0] IDX = CW'(i);
    assign req[i] = pend[i] & (IDX > pil_x);
  end

endmodule

// File: rtl/soft_irq_ctrl.sv
module soft_irq_ctrl #(
  parameter int PIL_W      = 4,
  parameter int TMR_THRESH = 14
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [1:0]               wr_sel,
  input  logic [(1<<PIL_W):0]      wr_data,
  input  logic                     pil_we,
  input  logic [PIL_W-1:0]         pil_wdata,
  input  logic                     tmr_set,
  output logic [(1<<PIL_W):0]      pend_q,
  output logic [PIL_W-1:0]         pil_q,
  output logic [(1<<PIL_W):0]      irq_req
);

  localparam int NLVL    = 1 << PIL_W;
  localparam int PEND_W  = NLVL + 1;
  localparam int PIL_RST = NLVL - 1;

  soft_irq_pend_reg #(.PEND_W(PEND_W)) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .tmr_set (tmr_set),
    .pend_q  (pend_q)
  );

  soft_irq_pil_reg #(.PIL_W(PIL_W), .PIL_RST(PIL_RST)) u_pil (
    .clk       (clk),
    .rst_n     (rst_n),
    .pil_we    (pil_we),
    .pil_wdata (pil_wdata),
    .pil_q     (pil_q)
  );

  soft_irq_mask #(.PIL_W(PIL_W), .NLVL(NLVL), .TMR_THRESH(TMR_THRESH)) u_mask (
    .pend (pend_q),
    .pil  (pil_q),
    .req  (irq_req)
  );

endmodule

// File: rtl/soft_irq_ctrl_chk.sv
module soft_irq_ctrl_chk #(
  parameter int PIL_W      = 4,
  parameter int TMR_THRESH = 14
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [1:0]          wr_sel,
  input logic [(1<<PIL_W):0] wr_data,
  input logic                pil_we,
  input logic [PIL_W-1:0]    pil_wdata,
  input logic                tmr_set,
  input logic [(1<<PIL_W):0] pend_q,
  input logic [PIL_W-1:0]    pil_q,
  input logic [(1<<PIL_W):0] irq_req
);

  localparam int NLVL = 1 << PIL_W;
  localparam logic [NLVL:0] LOW = {1'b0, {NLVL{1'b1}}};

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'b00) |=> ((pend_q & LOW) == ($past(wr_data) & LOW)));

  assert_set_or_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'b01) |=> ((pend_q & LOW) == (($past(pend_q) | $past(wr_data)) & LOW)));

  assert_clear_and_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'b10) |=> ((pend_q & LOW) == (($past(pend_q) & ~$past(wr_data)) & LOW)));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((!wr_en || wr_sel == 2'b11) && !tmr_set) |=> (pend_q == $past(pend_q)));

  for (genvar i = 1; i < NLVL; i++) begin : g_lvl_chk
    assert_level_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req[i] |-> (int'(pil_q) < i));
  end

  assert_fixed_thresh_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req[0] || irq_req[NLVL]) |-> (int'(pil_q) < TMR_THRESH));

  assert_pil_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pil_we |=> (pil_q == $past(pil_wdata)));

  assert_timer_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_set |=> pend_q[NLVL]);

  assert_req_subset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_req & ~pend_q) == '0));

endmodule

bind soft_irq_ctrl soft_irq_ctrl_chk #(.PIL_W(PIL_W), .TMR_THRESH(TMR_THRESH)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .wr_data   (wr_data),
  .pil_we    (pil_we),
  .pil_wdata (pil_wdata),
  .tmr_set   (tmr_set),
  .pend_q    (pend_q),
  .pil_q     (pil_q),
  .irq_req   (irq_req)
);

// File: tb/soft_irq_ctrl_tb.sv
`timescale 1ns/1ps
module soft_irq_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        en;
    logic [1:0]  sel;
    logic [16:0] data;
    logic        pwe;
    logic [3:0]  pil;
    logic        tmr;
    logic [16:0] e_pend;
    logic [16:0] e_irq;
  } vec_t;

  // Rows run in order from reset state (pending 0, floor 15).
  localparam vec_t TBL [12] = '{
    '{1'b1, 2'b00, 17'h1FFFF, 1'b0, 4'd0,  1'b0, 17'h1FFFF, 17'h00000}, // R2 R6 R7 floor 15
    '{1'b0, 2'b00, 17'h00000, 1'b1, 4'd13, 1'b0, 17'h1FFFF, 17'h1C001}, // R8 R7 R6 floor 13
    '{1'b0, 2'b00, 17'h00000, 1'b1, 4'd14, 1'b0, 17'h1FFFF, 17'h08000}, // R10 R7 floor 14
    '{1'b1, 2'b10, 17'h08000, 1'b0, 4'd0,  1'b0, 17'h17FFF, 17'h00000}, // R4
    '{1'b0, 2'b00, 17'h00000, 1'b1, 4'd0,  1'b0, 17'h17FFF, 17'h17FFF}, // R6 R7 floor 0
    '{1'b1, 2'b00, 17'h00000, 1'b0, 4'd0,  1'b0, 17'h00000, 17'h00000}, // R2
    '{1'b1, 2'b01, 17'h00005, 1'b0, 4'd0,  1'b1, 17'h10005, 17'h10005}, // R3 R9
    '{1'b1, 2'b10, 17'h10001, 1'b0, 4'd0,  1'b1, 17'h10004, 17'h10004}, // R9 R4 ordering
    '{1'b1, 2'b11, 17'h1FFFF, 1'b0, 4'd0,  1'b0, 17'h10004, 17'h10004}, // R5 code 11
    '{1'b0, 2'b00, 17'h00000, 1'b0, 4'd0,  1'b0, 17'h10004, 17'h10004}, // R5 idle
    '{1'b1, 2'b01, 17'h00060, 1'b1, 4'd5,  1'b0, 17'h10064, 17'h10040}, // R3 R8 R6
    '{1'b1, 2'b00, 17'h00001, 1'b0, 4'd0,  1'b1, 17'h10001, 17'h10001}  // R2 R9
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [16:0] wr_data;
  logic        pil_we;
  logic [3:0]  pil_wdata;
  logic        tmr_set;
  logic [16:0] pend_q;
  logic [3:0]  pil_q;
  logic [16:0] irq_req;

  int checks   = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  soft_irq_ctrl dut_i (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_sel (wr_sel),
    .wr_data (wr_data), .pil_we (pil_we), .pil_wdata (pil_wdata),
    .tmr_set (tmr_set), .pend_q (pend_q), .pil_q (pil_q), .irq_req (irq_req)
  );

  task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%05h expected=%05h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    wr_en = 1'b0; wr_sel = 2'b00; wr_data = '0;
    pil_we = 1'b0; pil_wdata = '0; tmr_set = 1'b0;
  endtask

  // Drive at negedge, let one posedge capture, sample at the following negedge.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 5000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 pend", pend_q, 17'h0);
    check("R1 pil", {13'b0, pil_q}, 17'd15);
    check("R1 irq", irq_req, 17'h0);

    for (int k = 0; k < 12; k++) begin
      wr_en = TBL[k].en; wr_sel = TBL[k].sel; wr_data = TBL[k].data;
      pil_we = TBL[k].pwe; pil_wdata = TBL[k].pil; tmr_set = TBL[k].tmr;
      step();
      check($sformatf("row%0d pend R2-5/R9", k), pend_q, TBL[k].e_pend);
      check($sformatf("row%0d irq R6/R7", k), irq_req, TBL[k].e_irq);
    end

    // R8: floor write only; pending untouched, requests follow next cycle.
    pil_we = 1'b1; pil_wdata = 4'd15;
    step();
    check("R8 pil", {13'b0, pil_q}, 17'd15);
    check("R8 pend kept", pend_q, 17'h10001);
    check("R10 irq dropped at floor 15", irq_req, 17'h0);

    // R7: floor 14 still masks the timer levels.
    pil_we = 1'b1; pil_wdata = 4'd14;
    step();
    check("R7 floor 14 blocks bit0/16", irq_req, 17'h0);

    // R6: bit 14 at floor 14 must stay masked, bit 15 passes.
    wr_en = 1'b1; wr_sel = 2'b00; wr_data = 17'h0C000;
    step();
    check("R6 strict compare", irq_req, 17'h08000);

    // R9: timer strobe alone leaves other bits intact.
    tmr_set = 1'b1;
    step();
    check("R9 timer only", pend_q, 17'h1C000);

    // R1: reset in the middle of activity.
    rst_n = 1'b0;
    step();
    rst_n = 1'b1;
    check("R1 mid reset pend", pend_q, 17'h0);
    check("R1 mid reset pil", {13'b0, pil_q}, 17'd15);
    check("R1 mid reset irq", irq_req, 17'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule